// File: doc/BRIEF.md
# Cartridge Bank-Switching Address Decoder

This block holds the bank registers of a game cartridge for an 8-bit console. The console has a 16-bit CPU address bus and a separate 14-bit video address bus. On every CPU write strobe the block decodes the address and the data bus and updates two registers:

- a program bank register, reset to 0xFF;
- a character bank register, reset to 0.

From these registers it forms the upper address lines of the program ROM and the character memory, together with a select line for each.

The CPU sees three regions:

- **$6000-$7FFF**: an 8 KB program window that can be switched.
- **$8000-$FFFF**: a fixed 32 KB window. It always shows the last four 8 KB banks of the ROM.
- **Video $0000-$1FFF**: an 8 KB character window that can be switched.

How a write is handled depends on its address:

- **Full write**: one class of addresses loads the whole data byte into both registers.
- **Partial write**: the $9000, $B000 and $D000 pages load only data bit 0, and only into the character register.

Bank numbers wrap modulo the bank count. The bank count is a parameter and must be a power of two.

The register outputs feed the address paths combinationally, so a new bank is visible in the cycle after the write edge. Nametable mirroring is a board strap outside this block, and the block has no interrupt.

Top module: `cart_bank_decoder`

## Requirements
- R1: After reset the $6000-$7FFF window selects program bank PRG_BANKS-1 (register value 0xFF taken modulo the bank count), and the character window selects bank 0.
- R2: While cpu_addr is in $6000-$7FFF, prg_rom_sel is 1 and prg_rom_addr = {prg_reg mod PRG_BANKS, cpu_addr[12:0]}.
- R3: While cpu_addr[15] is 1, prg_rom_sel is 1 and prg_rom_addr = {PRG_BANKS-4+cpu_addr[14:13], cpu_addr[12:0]}. Register writes do not change this mapping.
- R4: While ppu_addr[13] is 0, chr_rom_sel is 1 and chr_rom_addr = {chr_reg mod CHR_BANKS, ppu_addr[12:0]}. While ppu_addr[13] is 1, chr_rom_sel is 0.
- R5: A write whose address has bit 15 set and bit 12 clear, or whose address is $F000 or higher, loads the full data byte into both bank registers at the clock edge where cpu_wr is sampled high.
- R6: A write to the $9000, $B000 or $D000 page loads {7'b0, cpu_data[0]} into the character register and leaves the program register unchanged.
- R7: A write with cpu_addr below $8000 changes neither bank register.
- R8: While cpu_addr is below $6000, prg_rom_sel is 0.
- R9: While cpu_wr is 0, neither register changes, whatever the address and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, valid for one cycle per write |
| ppu_addr | input | 14 | Video address bus |
| prg_rom_addr | output | $clog2(PRG_BANKS)+13 | Program ROM address |
| prg_rom_sel | output | 1 | Program ROM select |
| chr_rom_addr | output | $clog2(CHR_BANKS)+13 | Character memory address |
| chr_rom_sel | output | 1 | Character memory select |

## Verification
The assertions assume the following about the inputs:
- cpu_wr is a clean, defined level at every rising edge.
- The address is stable in any cycle in which the strobe is high.
- PRG_BANKS and CHR_BANKS are powers of two with at least 4 banks for program ROM.

The stimulus meets these assumptions by changing every input only on the falling edge and by holding each write for exactly one cycle. It uses a configuration with 8 program and 8 character banks. All sixteen 4 KB pages are written with several data patterns, some with the strobe low. After every write the windows are swept and compared with a model kept in the bench.

// File: rtl/cart_bank_decoder.sv
module cart_bank_decoder #(
  parameter int PRG_BANKS = 16,
  parameter int CHR_BANKS = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [15:0]                    cpu_addr,
  input  logic [7:0]                     cpu_data,
  input  logic                           cpu_wr,
  input  logic [13:0]                    ppu_addr,
  output logic [$clog2(PRG_BANKS)+12:0]  prg_rom_addr,
  output logic                           prg_rom_sel,
  output logic [$clog2(CHR_BANKS)+12:0]  chr_rom_addr,
  output logic                           chr_rom_sel
);
  localparam int PB = $clog2(PRG_BANKS);
  localparam int CB = $clog2(CHR_BANKS);
  localparam logic [PB-1:0] FIX_BASE = PB'(PRG_BANKS - 4);

  logic [7:0] prg_q, chr_q;
  logic       full_wr, part_wr;
  logic [PB-1:0] prg_bank, fix_bank;
  logic [CB-1:0] chr_bank;

  assign full_wr = cpu_wr && cpu_addr[15] && (!cpu_addr[12] || cpu_addr[15:12] == 4'hF);
  assign part_wr = cpu_wr && cpu_addr[15] && !full_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prg_q <= 8'hFF;
      chr_q <= 8'h00;
    end else if (full_wr) begin
      prg_q <= cpu_data;
      chr_q <= cpu_data;
    end else if (part_wr) begin
      chr_q <= {7'b0, cpu_data[0]};
    end
  end

  assign prg_bank = prg_q[PB-1:0];
  assign chr_bank = chr_q[CB-1:0];
  assign fix_bank = FIX_BASE + {{(PB-2){1'b0}}, cpu_addr[14:13]};

  assign prg_rom_addr = {cpu_addr[15] ? fix_bank : prg_bank, cpu_addr[12:0]};
  assign prg_rom_sel  = cpu_addr[15] || (cpu_addr[14:13] == 2'b11);
  assign chr_rom_addr = {chr_bank, ppu_addr[12:0]};
  assign chr_rom_sel  = !ppu_addr[13];

  p_fixed_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[15] |-> (prg_rom_sel && prg_rom_addr[PB+12:13] >= FIX_BASE))
    else $error("fixed window left the last 32 KB");

  p_low_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !cpu_addr[15]) |=> ($stable(prg_q) && $stable(chr_q)))
    else $error("write below 8000 changed a bank register");

  p_partial_keeps_prg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15] && cpu_addr[12] && cpu_addr[15:12] != 4'hF)
      |=> ($stable(prg_q) && chr_q[7:1] == 7'b0))
    else $error("partial write touched program bank");

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> ($stable(prg_q) && $stable(chr_q)))
    else $error("register changed without strobe");

  p_switch_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (prg_rom_sel && !cpu_addr[15]) |-> prg_rom_addr[12:0] == cpu_addr[12:0])
    else $error("switchable window offset wrong");

  p_below_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr < 16'h6000) |-> !prg_rom_sel)
    else $error("select active below 6000");
endmodule

// File: tb/cart_bank_decoder_test.sv
module cart_bank_decoder_test;
  localparam int NP = 8;
  localparam int NC = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic        cpu_wr = 0;
  logic [13:0] ppu_addr = 14'h0000;
  logic [15:0] prg_rom_addr;
  logic        prg_rom_sel;
  logic [15:0] chr_rom_addr;
  logic        chr_rom_sel;

  int total = 0;
  int fails = 0;
  int exp_prg = 255;
  int exp_chr = 0;

  always #2 clk = ~clk;

  cart_bank_decoder #(.PRG_BANKS(NP), .CHR_BANKS(NC)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_rom_addr(prg_rom_addr),
    .prg_rom_sel(prg_rom_sel), .chr_rom_addr(chr_rom_addr), .chr_rom_sel(chr_rom_sel));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sweep(input string req);
    for (int k = 0; k < 4; k++) begin
      int off = (k * 16'h0777) & 16'h1FFF;
      cpu_addr = 16'h6000 | 16'(off);
      #1;
      check({req, " R2 prg window"}, int'(prg_rom_addr), (exp_prg % NP) * 8192 + off);
      check({req, " R2 prg sel"}, int'(prg_rom_sel), 1);
      cpu_addr = 16'h8000 | 16'(k * 16'h2000) | 16'(off);
      #1;
      check({req, " R3 fixed window"}, int'(prg_rom_addr), (NP - 4 + k) * 8192 + off);
      check({req, " R3 fixed sel"}, int'(prg_rom_sel), 1);
      ppu_addr = 14'(off);
      #1;
      check({req, " R4 chr window"}, int'(chr_rom_addr), (exp_chr % NC) * 8192 + off);
      check({req, " R4 chr sel"}, int'(chr_rom_sel), 1);
    end
    ppu_addr = 14'h2000;
    cpu_addr = 16'h5FFF;
    #1;
    check({req, " R4 chr sel high"}, int'(chr_rom_sel), 0);
    check({req, " R8 sel below 6000"}, int'(prg_rom_sel), 0);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input logic strobe);
    @(negedge clk);
    cpu_addr = a;
    cpu_data = d;
    cpu_wr = strobe;
    @(negedge clk);
    cpu_wr = 0;
    if (strobe && a[15]) begin
      if (!a[12] || a[15:12] == 4'hF) begin
        exp_prg = int'(d);
        exp_chr = int'(d);
      end else begin
        exp_chr = int'(d[0]);
      end
    end
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] vals [4] = '{8'h03, 8'h5A, 8'hFF, 8'hA6};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    sweep("R1 reset");
    for (int v = 0; v < 4; v++) begin
      for (int p = 0; p < 16; p++) begin
        logic [15:0] a = 16'(p << 12) | 16'(v * 16'h0135);
        do_write(a, vals[v] ^ 8'(p), 1'b1);
        sweep(a >= 16'hF000 ? "R5 F page" : (a[15] && a[12]) ? "R6 partial" :
              a[15] ? "R5 full" : "R7 low write");
        do_write(a, ~vals[v], 1'b0);
        sweep("R9 no strobe");
      end
    end
    do_write(16'hFFFF, 8'h05, 1'b1);
    sweep("R5 FFFF");
    do_write(16'h9000, 8'h04, 1'b1);
    sweep("R6 bit0 clear");
    @(negedge clk);
    rst_n = 0;
    exp_prg = 255;
    exp_chr = 0;
    @(negedge clk);
    rst_n = 1;
    sweep("R1 reset again");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule